// File: doc/BRIEF.md
# Synchronous Burst Read Timing Engine

This block sequences one synchronous, multi-beat read from an external memory whose address and data travel on separate lines, behind a single chip-select. A read request carries a start address and a beat count. The timing settings sit on the block's inputs and are latched when the request is taken. Each setting is a tick number, counted in functional-clock cycles from the start of the access. The block drives three active-low strobes: chip-select, address-valid and output-enable. It also drives a bus-direction level, a marker for external clock edges, and the address, which stays fixed for the whole access. It captures each returned data word into a registered output with a one-cycle valid pulse.

An access runs in three phases. In the lead phase, a tick counter runs from zero up to the first-data latency point. That point is either a fixed tick count or, in wait mode, the first cycle at that tick in which the active-low wait pin reads high. In the burst phase, the counter is held, so every strobe keeps its level while the remaining beats arrive at a fixed page interval. In the tail phase, the counter runs again until the end-of-cycle tick, where a done pulse closes the access. The external clock runs at the functional rate or at half that rate.

Top module: `brt_burst_read`

## Requirements
- R1: A request is taken only on a clock edge at which the block is idle. `busy_o` goes high in the next cycle and the tick counter starts at 0 there. A request made while busy starts nothing and changes no output.
- R2: While busy, each strobe is low exactly when the tick counter is at least its assert tick and below its deassert tick. If the deassert tick is at or below the assert tick, the strobe never goes low. All strobes are high while idle.
- R3: `mem_addr_o` holds the start address of the request for every cycle of the access.
- R4: With `wait_mode_i` = 0, the first beat is sampled from `mem_data_i` in the cycle where the counter equals the access tick, and `wait_n_i` has no effect. The beat appears on `rd_data_o`, with `rd_valid_o` high, in the following cycle.
- R5: With `wait_mode_i` = 1, the counter stalls at the access tick for as long as `wait_n_i` is sampled low there. The first beat is taken in the first cycle at that tick with `wait_n_i` high.
- R6: After the first beat, the counter, and with it every strobe level, is frozen for page × (beats − 1) cycles.
- R7: Each later beat is taken exactly page cycles after the previous one, with a page value of 0 treated as 1. `rd_last_o` is high together with `rd_valid_o` on the final beat only.
- R8: The number of beats delivered is the request count, with 0 taken as 1 and anything above MAX_BEATS taken as MAX_BEATS. A single beat has no frozen phase.
- R9: After the last beat, the counter resumes from access tick + 1 and saturates at 31. `done_o` pulses in the first such cycle whose count is at least the cycle-end tick, and the block is idle in the next cycle.
- R10: `bus_in_o` is high while busy and the counter is at or past the output-enable assert tick, and low otherwise.
- R11: `mclk_edge_o` marks external clock rising edges. With `div2_i` = 0 it is high in every busy cycle. With `div2_i` = 1 it is high in busy cycles 0, 2, 4 and so on, counted from the first busy cycle. It is low while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Start a read access |
| req_addr_i | input | ADDR_W | Start address |
| req_beats_i | input | $clog2(MAX_BEATS)+1 | Requested beat count |
| cs_on_i | input | 4 | Chip-select assert tick |
| cs_off_i | input | 5 | Chip-select deassert tick |
| adv_on_i | input | 4 | Address-valid assert tick |
| adv_off_i | input | 5 | Address-valid deassert tick |
| oe_on_i | input | 4 | Output-enable assert tick |
| oe_off_i | input | 5 | Output-enable deassert tick |
| access_i | input | 5 | First-data latency tick |
| page_i | input | 4 | Interval between later beats |
| cycle_i | input | 5 | Cycle-end tick |
| wait_mode_i | input | 1 | First beat gated by the wait pin |
| div2_i | input | 1 | External clock at half rate |
| wait_n_i | input | 1 | Active-low wait from the memory |
| mem_data_i | input | DATA_W | Data from the memory |
| busy_o | output | 1 | Access in progress |
| mem_addr_o | output | ADDR_W | Address to the memory |
| cs_n_o | output | 1 | Chip-select, active low |
| adv_n_o | output | 1 | Address-valid, active low |
| oe_n_o | output | 1 | Output-enable, active low |
| bus_in_o | output | 1 | Data bus turned toward the block |
| mclk_edge_o | output | 1 | External clock rising-edge marker |
| rd_data_o | output | DATA_W | Captured beat |
| rd_valid_o | output | 1 | Captured beat valid |
| rd_last_o | output | 1 | Final beat of the access |
| done_o | output | 1 | Access ends this cycle |

## Verification
The bench builds the block with its defaults: ADDR_W = 10, DATA_W = 16 and MAX_BEATS = 8. With these, the full eight-beat freeze is reachable, as are both clamping cases of the beat count (0 and values above 8 from a 4-bit request). The 5-bit counter can be driven into saturation at 31 by setting the access tick to its maximum. Random settings also produce deassert ticks below assert ticks, cycle-end ticks inside the lead phase, and page values of 0.

// File: rtl/brt_pkg.sv
package brt_pkg;
  localparam int ON_W  = 4;
  localparam int OFF_W = 5;
  localparam int CNT_W = OFF_W;
  localparam int PG_W  = 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEAD,
    ST_FREEZE,
    ST_TAIL
  } brt_state_e;

  typedef struct packed {
    logic [ON_W-1:0]  cs_on;
    logic [OFF_W-1:0] cs_off;
    logic [ON_W-1:0]  adv_on;
    logic [OFF_W-1:0] adv_off;
    logic [ON_W-1:0]  oe_on;
    logic [OFF_W-1:0] oe_off;
    logic [CNT_W-1:0] access;
    logic [PG_W-1:0]  page;
    logic [CNT_W-1:0] cycle;
    logic             wait_mode;
    logic             div2;
  } brt_cfg_t;
endpackage

// File: rtl/brt_tick_counter.sv
module brt_tick_counter #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (inc && (cnt_q != CNT_MAX))
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/brt_strobe.sv
module brt_strobe #(
  parameter int ON_W  = 4,
  parameter int OFF_W = 5
) (
  input  logic             busy,
  input  logic [OFF_W-1:0] cnt,
  input  logic [ON_W-1:0]  on_tick,
  input  logic [OFF_W-1:0] off_tick,
  output logic             strobe_n
);
  logic [OFF_W-1:0] on_ext;
  logic             active;

  assign on_ext   = OFF_W'(on_tick);
  assign active   = busy && (cnt >= on_ext) && (cnt < off_tick);
  assign strobe_n = !active;
endmodule

// File: rtl/brt_sequencer.sv
module brt_sequencer
  import brt_pkg::*;
#(
  parameter int BEAT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [BEAT_W-1:0] beats_m1,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  access,
  input  logic [PG_W-1:0]   page,
  input  logic [CNT_W-1:0]  cycle,
  input  logic              wait_mode,
  input  logic              wait_n,
  output logic              accept,
  output logic              busy,
  output logic              frozen,
  output logic              cnt_clr,
  output logic              cnt_inc,
  output logic              capture,
  output logic              last_beat,
  output logic              done
);
  brt_state_e        state_q, state_d;
  logic [BEAT_W-1:0] left_q, left_d;
  logic [PG_W-1:0]   pg_q, pg_d;
  logic [PG_W-1:0]   page_eff;

  assign page_eff = (page == '0) ? PG_W'(1) : page;

  always_comb begin
    state_d   = state_q;
    left_d    = left_q;
    pg_d      = pg_q;
    accept    = 1'b0;
    cnt_clr   = 1'b0;
    cnt_inc   = 1'b0;
    capture   = 1'b0;
    last_beat = 1'b0;
    done      = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req) begin
          accept  = 1'b1;
          cnt_clr = 1'b1;
          left_d  = beats_m1;
          state_d = ST_LEAD;
        end
      end
      ST_LEAD: begin
        if (cnt == access) begin
          if (!wait_mode || wait_n) begin
            capture = 1'b1;
            if (left_q == '0) begin
              last_beat = 1'b1;
              cnt_inc   = 1'b1;
              state_d   = ST_TAIL;
            end else begin
              pg_d    = PG_W'(1);
              state_d = ST_FREEZE;
            end
          end
        end else begin
          cnt_inc = 1'b1;
        end
      end
      ST_FREEZE: begin
        if (pg_q == page_eff) begin
          capture = 1'b1;
          left_d  = left_q - 1'b1;
          pg_d    = PG_W'(1);
          if (left_q == BEAT_W'(1)) begin
            last_beat = 1'b1;
            cnt_inc   = 1'b1;
            state_d   = ST_TAIL;
          end
        end else begin
          pg_d = pg_q + 1'b1;
        end
      end
      ST_TAIL: begin
        if (cnt >= cycle) begin
          done    = 1'b1;
          state_d = ST_IDLE;
        end else begin
          cnt_inc = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
      pg_q    <= '0;
    end else begin
      state_q <= state_d;
      left_q  <= left_d;
      pg_q    <= pg_d;
    end
  end

  assign busy   = (state_q != ST_IDLE);
  assign frozen = (state_q == ST_FREEZE);
endmodule

// File: rtl/brt_capture.sv
module brt_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              last_beat,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              rd_last
);
  logic [DATA_W-1:0] data_q;
  logic              valid_q, last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      if (capture) data_q <= data_in;
      valid_q <= capture;
      last_q  <= capture && last_beat;
    end
  end

  assign rd_data  = data_q;
  assign rd_valid = valid_q;
  assign rd_last  = last_q;
endmodule

// File: rtl/brt_burst_read.sv
module brt_burst_read
  import brt_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 16,
  parameter int MAX_BEATS = 8,
  localparam int BEAT_W   = $clog2(MAX_BEATS),
  localparam int REQ_W    = BEAT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [REQ_W-1:0]  req_beats_i,
  input  logic [ON_W-1:0]   cs_on_i,
  input  logic [OFF_W-1:0]  cs_off_i,
  input  logic [ON_W-1:0]   adv_on_i,
  input  logic [OFF_W-1:0]  adv_off_i,
  input  logic [ON_W-1:0]   oe_on_i,
  input  logic [OFF_W-1:0]  oe_off_i,
  input  logic [CNT_W-1:0]  access_i,
  input  logic [PG_W-1:0]   page_i,
  input  logic [CNT_W-1:0]  cycle_i,
  input  logic              wait_mode_i,
  input  logic              div2_i,
  input  logic              wait_n_i,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              cs_n_o,
  output logic              adv_n_o,
  output logic              oe_n_o,
  output logic              bus_in_o,
  output logic              mclk_edge_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic              rd_last_o,
  output logic              done_o
);
  localparam int NSTROBE = 3;

  brt_cfg_t          cfg_in, cfg_q;
  logic [ADDR_W-1:0] addr_q;
  logic              phase_q, phase_d;
  logic [BEAT_W-1:0] beats_m1;
  logic [CNT_W-1:0]  cnt;
  logic              accept, busy, frozen_w, cnt_clr, cnt_inc;
  logic              capture, last_beat, done;

  logic [ON_W-1:0]    on_ticks  [NSTROBE];
  logic [OFF_W-1:0]   off_ticks [NSTROBE];
  logic [NSTROBE-1:0] strobes_n;

  always_comb begin
    if (req_beats_i == '0)
      beats_m1 = '0;
    else if (req_beats_i > REQ_W'(MAX_BEATS))
      beats_m1 = BEAT_W'(MAX_BEATS - 1);
    else
      beats_m1 = BEAT_W'(req_beats_i - 1'b1);
  end

  always_comb begin
    cfg_in.cs_on     = cs_on_i;
    cfg_in.cs_off    = cs_off_i;
    cfg_in.adv_on    = adv_on_i;
    cfg_in.adv_off   = adv_off_i;
    cfg_in.oe_on     = oe_on_i;
    cfg_in.oe_off    = oe_off_i;
    cfg_in.access    = access_i;
    cfg_in.page      = page_i;
    cfg_in.cycle     = cycle_i;
    cfg_in.wait_mode = wait_mode_i;
    cfg_in.div2      = div2_i;
  end

  always_comb begin
    phase_d = phase_q;
    if (accept)    phase_d = 1'b0;
    else if (busy) phase_d = !phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      addr_q  <= '0;
      phase_q <= 1'b0;
    end else begin
      if (accept) begin
        cfg_q  <= cfg_in;
        addr_q <= req_addr_i;
      end
      phase_q <= phase_d;
    end
  end

  brt_sequencer #(.BEAT_W(BEAT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req_i),
    .beats_m1  (beats_m1),
    .cnt       (cnt),
    .access    (cfg_q.access),
    .page      (cfg_q.page),
    .cycle     (cfg_q.cycle),
    .wait_mode (cfg_q.wait_mode),
    .wait_n    (wait_n_i),
    .accept    (accept),
    .busy      (busy),
    .frozen    (frozen_w),
    .cnt_clr   (cnt_clr),
    .cnt_inc   (cnt_inc),
    .capture   (capture),
    .last_beat (last_beat),
    .done      (done)
  );

  brt_tick_counter #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .inc   (cnt_inc),
    .cnt_o (cnt)
  );

  assign on_ticks[0]  = cfg_q.cs_on;
  assign off_ticks[0] = cfg_q.cs_off;
  assign on_ticks[1]  = cfg_q.adv_on;
  assign off_ticks[1] = cfg_q.adv_off;
  assign on_ticks[2]  = cfg_q.oe_on;
  assign off_ticks[2] = cfg_q.oe_off;

  for (genvar g = 0; g < NSTROBE; g++) begin : g_strobe
    brt_strobe #(.ON_W(ON_W), .OFF_W(OFF_W)) u_strobe (
      .busy     (busy),
      .cnt      (cnt),
      .on_tick  (on_ticks[g]),
      .off_tick (off_ticks[g]),
      .strobe_n (strobes_n[g])
    );
  end

  brt_capture #(.DATA_W(DATA_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (capture),
    .last_beat (last_beat),
    .data_in   (mem_data_i),
    .rd_data   (rd_data_o),
    .rd_valid  (rd_valid_o),
    .rd_last   (rd_last_o)
  );

  assign busy_o      = busy;
  assign mem_addr_o  = addr_q;
  assign cs_n_o      = strobes_n[0];
  assign adv_n_o     = strobes_n[1];
  assign oe_n_o      = strobes_n[2];
  assign bus_in_o    = busy && (cnt >= CNT_W'(cfg_q.oe_on));
  assign mclk_edge_o = busy && (!cfg_q.div2 || !phase_q);
  assign done_o      = done;
endmodule

// File: rtl/brt_checker.sv
module brt_checker #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic              busy,
  input logic              frozen,
  input logic [ADDR_W-1:0] addr,
  input logic              cs_n,
  input logic              adv_n,
  input logic              oe_n,
  input logic              rd_valid,
  input logic              rd_last,
  input logic              done,
  input logic              mclk_edge
);
  assert_accept_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req) |=> busy);

  assert_idle_strobes_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n && adv_n && oe_n));

  assert_addr_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(addr));

  assert_valid_in_access_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> busy);

  assert_freeze_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && $past(frozen)) |-> $stable({cs_n, adv_n, oe_n}));

  assert_last_with_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last |-> rd_valid);

  assert_done_to_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  assert_edge_idle_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mclk_edge);
endmodule

bind brt_burst_read brt_checker #(.ADDR_W(ADDR_W)) u_brt_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .req       (req_i),
  .busy      (busy_o),
  .frozen    (frozen_w),
  .addr      (mem_addr_o),
  .cs_n      (cs_n_o),
  .adv_n     (adv_n_o),
  .oe_n      (oe_n_o),
  .rd_valid  (rd_valid_o),
  .rd_last   (rd_last_o),
  .done      (done_o),
  .mclk_edge (mclk_edge_o)
);

// File: tb/tb_brt_burst_read.sv
`timescale 1ns/1ps
module tb_brt_burst_read;
  localparam int ADDR_W    = 10;
  localparam int DATA_W    = 16;
  localparam int MAX_BEATS = 8;
  localparam int REQ_W     = $clog2(MAX_BEATS) + 1;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n, req_i, wait_mode_i, div2_i, wait_n_i;
  logic [ADDR_W-1:0] req_addr_i;
  logic [REQ_W-1:0]  req_beats_i;
  logic [3:0]        cs_on_i, adv_on_i, oe_on_i, page_i;
  logic [4:0]        cs_off_i, adv_off_i, oe_off_i, access_i, cycle_i;
  logic [DATA_W-1:0] mem_data_i;
  logic              busy_o, cs_n_o, adv_n_o, oe_n_o, bus_in_o, mclk_edge_o;
  logic              rd_valid_o, rd_last_o, done_o;
  logic [ADDR_W-1:0] mem_addr_o;
  logic [DATA_W-1:0] rd_data_o;

  brt_burst_read #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_BEATS(MAX_BEATS)) dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .req_addr_i(req_addr_i),
    .req_beats_i(req_beats_i), .cs_on_i(cs_on_i), .cs_off_i(cs_off_i),
    .adv_on_i(adv_on_i), .adv_off_i(adv_off_i), .oe_on_i(oe_on_i),
    .oe_off_i(oe_off_i), .access_i(access_i), .page_i(page_i),
    .cycle_i(cycle_i), .wait_mode_i(wait_mode_i), .div2_i(div2_i),
    .wait_n_i(wait_n_i), .mem_data_i(mem_data_i), .busy_o(busy_o),
    .mem_addr_o(mem_addr_o), .cs_n_o(cs_n_o), .adv_n_o(adv_n_o),
    .oe_n_o(oe_n_o), .bus_in_o(bus_in_o), .mclk_edge_o(mclk_edge_o),
    .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o), .rd_last_o(rd_last_o),
    .done_o(done_o)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  task automatic chk(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_cnt(int j, int a, int s, int p, int b);
    int fz = a + s + p * (b - 1);
    int v;
    if (j <= a) return j;
    if (j <= fz) return a;
    v = j - s - p * (b - 1);
    return (v > 31) ? 31 : v;
  endfunction

  function automatic int is_low(int c, int on, int off);
    return (c >= on && c < off) ? 1 : 0;
  endfunction

  function automatic logic [DATA_W-1:0] data_of(int j);
    return DATA_W'(j * 291 + 23055);
  endfunction

  task automatic run_access(int addr, int raw_b, int cs_on, int cs_off, int adv_on,
                            int adv_off, int oe_on, int oe_off, int a, int p, int cyc,
                            bit wm, int w, bit d2, bit inject);
    int b, pe, s, fz, c, k, seen, inj_addr;
    bit dn, cap;
    b  = (raw_b == 0) ? 1 : ((raw_b > MAX_BEATS) ? MAX_BEATS : raw_b);
    pe = (p == 0) ? 1 : p;
    s  = wm ? w : 0;
    fz = a + s + pe * (b - 1);
    seen = 0;
    inj_addr = (addr + 17) % (1 << ADDR_W);
    @(negedge clk);
    req_i = 1'b1; req_addr_i = ADDR_W'(addr); req_beats_i = REQ_W'(raw_b);
    cs_on_i = 4'(cs_on); cs_off_i = 5'(cs_off); adv_on_i = 4'(adv_on);
    adv_off_i = 5'(adv_off); oe_on_i = 4'(oe_on); oe_off_i = 5'(oe_off);
    access_i = 5'(a); page_i = 4'(p); cycle_i = 5'(cyc);
    wait_mode_i = wm; div2_i = d2; wait_n_i = 1'b1;
    for (int j = 0; j < 400; j++) begin
      @(negedge clk);
      c  = exp_cnt(j, a, s, pe, b);
      dn = (j > fz) && (c >= cyc);
      chk("R1 busy during access", busy_o, 1);
      chk((j > a + s && j <= fz) ? "R6 cs_n frozen" : "R2 cs_n", cs_n_o, 1 - is_low(c, cs_on, cs_off));
      chk((j > a + s && j <= fz) ? "R6 adv_n frozen" : "R2 adv_n", adv_n_o, 1 - is_low(c, adv_on, adv_off));
      chk((j > a + s && j <= fz) ? "R6 oe_n frozen" : "R2 oe_n", oe_n_o, 1 - is_low(c, oe_on, oe_off));
      chk("R3 address held", int'(mem_addr_o), addr);
      chk("R10 bus_in", bus_in_o, (c >= oe_on) ? 1 : 0);
      chk("R11 mclk_edge", mclk_edge_o, (!d2 || (j % 2 == 0)) ? 1 : 0);
      k = j - 1 - (a + s);
      cap = (j >= 1) && (k >= 0) && (k % pe == 0) && (k / pe < b);
      chk((k == 0) ? (wm ? "R5 first beat valid" : "R4 first beat valid") : "R7 beat valid",
          rd_valid_o, cap ? 1 : 0);
      if (cap) begin
        seen++;
        chk((k == 0) ? (wm ? "R5 first beat data" : "R4 first beat data") : "R7 beat data",
            int'(rd_data_o), int'(data_of(j - 1)));
        chk("R7 last flag", rd_last_o, (k / pe == b - 1) ? 1 : 0);
      end
      chk("R9 done", done_o, dn ? 1 : 0);
      mem_data_i = data_of(j);
      if (wm) wait_n_i = (j >= a && j < a + w) ? 1'b0 : 1'b1;
      else    wait_n_i = (j >= a && j < a + 3) ? 1'b0 : 1'b1;
      if (dn) begin
        req_i = 1'b0;
        break;
      end
      req_i = (inject && j == 1) ? 1'b1 : 1'b0;
      req_addr_i = ADDR_W'(inj_addr);
    end
    @(negedge clk);
    req_i = 1'b0;
    chk("R8 beat count", seen, b);
    chk("R9 idle after done", busy_o, 0);
    chk("R2 idle cs_n", cs_n_o, 1);
    chk("R11 idle mclk_edge", mclk_edge_o, 0);
    chk("R1 no extra access", rd_valid_o, 0);
    wait_n_i = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; req_i = 1'b0; req_addr_i = '0; req_beats_i = '0;
    cs_on_i = '0; cs_off_i = '0; adv_on_i = '0; adv_off_i = '0;
    oe_on_i = '0; oe_off_i = '0; access_i = '0; page_i = '0; cycle_i = '0;
    wait_mode_i = 1'b0; div2_i = 1'b0; wait_n_i = 1'b1; mem_data_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset busy", busy_o, 0);
    chk("R2 reset strobes", {29'd0, cs_n_o, adv_n_o, oe_n_o}, 7);
    chk("R9 reset done", done_o, 0);
    chk("R4 reset valid", rd_valid_o, 0);

    // R8 single beat, no freeze; R4 wait ignored in counter mode
    run_access(12, 1, 1, 6, 0, 3, 2, 7, 4, 2, 8, 1'b0, 0, 1'b0, 1'b0);
    // R6 R7 full burst, page 1
    run_access(300, 8, 0, 20, 1, 2, 3, 18, 5, 1, 12, 1'b0, 0, 1'b0, 1'b0);
    // R5 wait-gated first beat, page 2, half-rate clock
    run_access(513, 4, 2, 25, 0, 4, 3, 22, 6, 2, 14, 1'b1, 3, 1'b1, 1'b0);
    // R2 deassert tick below assert tick: adv never low
    run_access(77, 3, 1, 15, 9, 4, 2, 15, 5, 3, 10, 1'b0, 0, 1'b0, 1'b0);
    // R8 clamp: 0 -> 1 and 12 -> 8; R7 page 0 treated as 1
    run_access(5, 0, 0, 9, 0, 1, 1, 9, 3, 0, 6, 1'b0, 0, 1'b1, 1'b0);
    run_access(6, 12, 0, 31, 0, 1, 1, 31, 2, 0, 20, 1'b0, 0, 1'b0, 1'b0);
    // R9 saturation at 31
    run_access(1000, 2, 3, 31, 0, 2, 4, 31, 31, 1, 31, 1'b0, 0, 1'b1, 1'b0);
    // R1 request while busy ignored
    run_access(400, 2, 1, 10, 0, 2, 2, 9, 4, 2, 9, 1'b0, 0, 1'b0, 1'b1);
    // R9 cycle end inside lead phase
    run_access(9, 1, 0, 3, 0, 1, 0, 3, 0, 1, 0, 1'b0, 0, 1'b0, 1'b1);

    for (int n = 0; n < 30; n++) begin
      run_access(int'($urandom_range(1023, 0)), int'($urandom_range(10, 0)),
                 int'($urandom_range(15, 0)), int'($urandom_range(31, 0)),
                 int'($urandom_range(15, 0)), int'($urandom_range(31, 0)),
                 int'($urandom_range(15, 0)), int'($urandom_range(31, 0)),
                 int'($urandom_range(20, 0)), int'($urandom_range(4, 0)),
                 int'($urandom_range(31, 0)), 1'($urandom_range(1, 0)),
                 int'($urandom_range(3, 0)), 1'($urandom_range(1, 0)),
                 1'($urandom_range(1, 0)));
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule